// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the data-processing core of a small processor datapath. It combines a 32-bit combinational integer unit with a four-bit condition register that holds the negative, zero, carry and overflow flags. Each cycle it takes two operands, a four-bit operation code and a flag-write request. It returns the computed value, a strobe saying whether that value should be stored, and the flag state that the next clock edge will capture. The carry used by the carry-chained operations is the carry bit already held in the register. This lets multi-word sums and differences be built from a sequence of single-word steps.

The unit covers four groups of operations:
- four arithmetic operations: plain and carry-chained addition and subtraction;
- four bitwise operations: AND, OR, XOR and AND-with-complement;
- two pass operations, one plain and one inverting, on the second operand;
- four flag-only operations, which compare or test the operands without producing a value to store.

A separate clear input zeroes all four flags in a single cycle.

Top module: `nzcv_alu`

## Requirements
- R1: Opcode 4 gives a+b, 5 gives a+b+C, 2 gives a-b, and 6 gives a-b+C-1, where C is the stored carry flag. Each of these asserts `res_we`.
- R2: Opcode 0 gives a AND b, 12 gives a OR b, 1 gives a XOR b, and 14 gives a AND NOT b. Opcode 13 passes b and opcode 15 passes NOT b. Each of these asserts `res_we`.
- R3: The flags port is packed as bit 3 N, bit 2 Z, bit 1 C and bit 0 V. On any flag write, N takes bit 31 of the computed value, and Z is 1 exactly when all 32 bits of that value are 0.
- R4: On a flag write by an addition, C is the carry out of bit 31. On a flag write by a subtraction, C is 1 when the unsigned a is greater than or equal to the subtracted operand, meaning no borrow occurs.
- R5: On a flag write by an arithmetic operation, V is 1 only when the two effective addends share a sign and the sum has the other sign. For subtraction the second addend is NOT b.
- R6: The bitwise and pass opcodes (0, 1, 12, 13, 14, 15) update only N and Z when `set_flags` is 1. C and V keep their values.
- R7: Opcodes 8 (a AND b), 9 (a XOR b), 10 (a-b) and 11 (a+b) hold `res_we` low and write flags even when `set_flags` is 0. Opcodes 10 and 11 write all four flags. Opcodes 8 and 9 write only N and Z.
- R8: For any opcode outside the range 8 to 11, the flags hold when `set_flags` is 0.
- R9: When `clr_flags` is 1, all four flags become 0 at the next edge, whatever the opcode and `set_flags` are.
- R10: Opcodes 3 and 7 hold `res_we` low and leave the flags unchanged.
- R11: A synchronous active-high `rst` sets the flags to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| set_flags | input | 1 | Flag-write request for non-compare operations |
| clr_flags | input | 1 | Force all flags to zero |
| res | output | 32 | Combinational result |
| res_we | output | 1 | Result should be stored |
| flags | output | 4 | Registered N, Z, C, V |
| flags_nxt | output | 4 | Flag value loaded at the next edge |

## Verification
The bench uses the default width of 32 bits. At this width, the signed boundary values 0x7FFFFFFF and 0x80000000 and the all-ones operand sit exactly where V, C and Z flip. A table run from cleared flags covers every opcode. Directed sequences then cover the cases that depend on flag history:
- a two-word addition whose low half carries into the high half;
- carry-chained subtraction with both carry values;
- C and V surviving a bitwise operation and a test operation;
- clear taking priority over a write;
- reserved codes leaving the flags alone.

// File: rtl/nzcv_alu.sv
module nzcv_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         set_flags,
  input  logic         clr_flags,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [3:0]   flags,
  output logic [3:0]   flags_nxt
);
  localparam logic [3:0] OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_ADD = 4'd4;
  localparam logic [3:0] OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_TST = 4'd8,  OP_TEQ = 4'd9;
  localparam logic [3:0] OP_CMP = 4'd10, OP_CMN = 4'd11, OP_ORR = 4'd12, OP_MOV = 4'd13;
  localparam logic [3:0] OP_BIC = 4'd14, OP_MVN = 4'd15;

  logic         c_q;
  logic         is_add, is_sub, is_arith, is_cmp, is_rsv, is_logic;
  logic         cin, v_raw, upd_nz, upd_cv;
  logic [W-1:0] y;
  logic [W:0]   sum;

  assign c_q      = flags[1];
  assign is_add   = (op == OP_ADD) || (op == OP_ADC) || (op == OP_CMN);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign is_arith = is_add || is_sub;
  assign is_cmp   = (op[3:2] == 2'b10);
  assign is_rsv   = (op == 4'd3) || (op == 4'd7);
  assign is_logic = !is_arith && !is_cmp && !is_rsv;

  assign y   = is_sub ? ~b : b;
  assign cin = ((op == OP_ADC) || (op == OP_SBC)) ? c_q : (op == OP_SUB) || (op == OP_CMP);
  assign sum = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
  assign v_raw = (a[W-1] == y[W-1]) && (sum[W-1] != a[W-1]);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_BIC:         res = a & ~b;
      OP_MOV:         res = b;
      OP_MVN:         res = ~b;
      default:        res = is_arith ? sum[W-1:0] : '0;
    endcase
  end

  assign res_we = !is_cmp && !is_rsv;
  assign upd_nz = !is_rsv && (is_cmp || set_flags);
  assign upd_cv = is_arith && (is_cmp || set_flags);

  always_comb begin
    if (clr_flags) flags_nxt = 4'b0000;
    else flags_nxt = { upd_nz ? res[W-1]   : flags[3],
                       upd_nz ? (res == '0) : flags[2],
                       upd_cv ? sum[W]     : flags[1],
                       upd_cv ? v_raw      : flags[0] };
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= 4'b0000;
    else     flags <= flags_nxt;
  end

  // R6
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (rst)
    (is_logic && !clr_flags) |=> (flags[1:0] == $past(flags[1:0])));
  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    is_cmp |-> !res_we);
  // R8
  hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_flags && !is_cmp && !clr_flags) |=> $stable(flags));
  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
    clr_flags |=> (flags == 4'b0000));
  // R10
  reserved_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rsv && !clr_flags) |=> ($stable(flags) && $past(!res_we)));
  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (is_arith && set_flags && !clr_flags) |=> (flags[2] == ($past(res) == '0)));
endmodule

// File: tb/test_nzcv_alu.sv
`timescale 1ns/1ps
module test_nzcv_alu;
  logic        clk = 0, rst = 1;
  logic [3:0]  op = 0;
  logic [31:0] a = 0, b = 0;
  logic        set_flags = 0, clr_flags = 0;
  logic [31:0] res;
  logic        res_we;
  logic [3:0]  flags, flags_nxt;
  int checks = 0, fails = 0;
  bit done = 0;

  nzcv_alu i_nzcv_alu (.clk(clk), .rst(rst), .op(op), .a(a), .b(b), .set_flags(set_flags),
    .clr_flags(clr_flags), .res(res), .res_we(res_we), .flags(flags), .flags_nxt(flags_nxt));

  always #5 clk = ~clk;

  // {op, a, b, exp_res, exp_we, exp_flags}; applied with set_flags=1 after a flag clear
  localparam int NV = 20;
  localparam logic [104:0] VEC [NV] = '{
    {4'd4,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 4'b1001},
    {4'd4,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 4'b0110},
    {4'd2,  32'h00000011, 32'h00000023, 32'hFFFFFFEE, 1'b1, 4'b1000},
    {4'd2,  32'h00000023, 32'h00000011, 32'h00000012, 1'b1, 4'b0010},
    {4'd2,  32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'b0011},
    {4'd2,  32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 4'b0110},
    {4'd4,  32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 4'b0111},
    {4'd0,  32'h00000055, 32'h00000061, 32'h00000041, 1'b1, 4'b0000},
    {4'd12, 32'h00000055, 32'h00000061, 32'h00000075, 1'b1, 4'b0000},
    {4'd1,  32'h00000055, 32'h00000061, 32'h00000034, 1'b1, 4'b0000},
    {4'd14, 32'h00000055, 32'h00000061, 32'h00000014, 1'b1, 4'b0000},
    {4'd13, 32'h00000000, 32'h0000000C, 32'h0000000C, 1'b1, 4'b0000},
    {4'd15, 32'h00000000, 32'h0000000C, 32'hFFFFFFF3, 1'b1, 4'b1000},
    {4'd13, 32'h12345678, 32'h00000000, 32'h00000000, 1'b1, 4'b0100},
    {4'd10, 32'h00000011, 32'h00000023, 32'h0,        1'b0, 4'b1000},
    {4'd10, 32'h00000005, 32'h00000005, 32'h0,        1'b0, 4'b0110},
    {4'd11, 32'h7FFFFFFF, 32'h00000001, 32'h0,        1'b0, 4'b1001},
    {4'd8,  32'h0000000F, 32'h000000F0, 32'h0,        1'b0, 4'b0100},
    {4'd9,  32'h0000000F, 32'h000000F0, 32'h0,        1'b0, 4'b0000},
    {4'd8,  32'h80000000, 32'h80000001, 32'h0,        1'b0, 4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic s, input logic c);
    @(negedge clk);
    op = o; a = x; b = y; set_flags = s; clr_flags = c;
    #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
    set_flags = 0; clr_flags = 0; op = 4'd3;
  endtask

  task automatic clear;
    drive(4'd3, 0, 0, 0, 1); tick();
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset flags", {28'd0, flags}, 32'h0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [104:0] v;
      v = VEC[i];
      clear();
      drive(v[104:101], v[100:69], v[68:37], 1'b1, 1'b0);
      if (v[4]) chk($sformatf("R1/R2 result vec %0d", i), res, v[36:5]);
      chk($sformatf("R7 res_we vec %0d", i), {31'd0, res_we}, {31'd0, v[4]});
      tick();
      chk($sformatf("R3/R4/R5 flags vec %0d", i), {28'd0, flags}, {28'd0, v[3:0]});
    end

    // R1 chained 64-bit add: 0x1_FFFFFFFF + 0x2_00000001
    clear();
    drive(4'd4, 32'hFFFFFFFF, 32'h00000001, 1, 0);
    chk("R1 low word", res, 32'h0);
    tick();
    chk("R4 low carry", {31'd0, flags[1]}, 32'h1);
    drive(4'd5, 32'h1, 32'h2, 1, 0);
    chk("R1 ADC high word", res, 32'h4);
    tick();
    chk("R4 ADC flags", {28'd0, flags}, 32'h0);

    // R1 SBC with C=0 and C=1
    drive(4'd6, 32'h5, 32'h3, 1, 0);
    chk("R1 SBC C=0", res, 32'h1);
    tick();
    chk("R4 SBC no borrow", {28'd0, flags}, 32'h2);
    drive(4'd6, 32'h5, 32'h3, 1, 0);
    chk("R1 SBC C=1", res, 32'h2);
    tick();

    // R8 hold when set_flags low
    clear();
    drive(4'd4, 32'h7FFFFFFF, 32'h1, 1, 0); tick();
    drive(4'd4, 32'h0, 32'h0, 0, 0);
    chk("R8 result still written", {31'd0, res_we}, 32'h1);
    tick();
    chk("R8 flags held", {28'd0, flags}, 32'h9);

    // R10 reserved codes
    drive(4'd3, 32'h0, 32'h0, 1, 0);
    chk("R10 op3 no write", {31'd0, res_we}, 32'h0);
    tick();
    drive(4'd7, 32'h0, 32'h0, 1, 0);
    chk("R10 op7 no write", {31'd0, res_we}, 32'h0);
    tick();
    chk("R10 flags unchanged", {28'd0, flags}, 32'h9);

    // R6 logical keeps C,V; R7 TST keeps C,V
    clear();
    drive(4'd4, 32'h80000000, 32'h80000000, 1, 0); tick();
    drive(4'd12, 32'h1, 32'h0, 1, 0); tick();
    chk("R6 ORR keeps C V", {28'd0, flags}, 32'h3);
    drive(4'd8, 32'h80000000, 32'h80000000, 0, 0); tick();
    chk("R7 TST writes NZ only", {28'd0, flags}, 32'hB);

    // R9 clear beats a write
    drive(4'd4, 32'h7FFFFFFF, 32'h1, 1, 1); tick();
    chk("R9 clear priority", {28'd0, flags}, 32'h0);

    // R11 reset mid-run
    drive(4'd4, 32'hFFFFFFFF, 32'h1, 1, 0); tick();
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk("R11 reset clears", {28'd0, flags}, 32'h0);
    rst = 0;

    done = 1;
    finish_run();
  end
endmodule